// File: doc/BRIEF.md
# Multiplexed Card-Controller Bus Master

This block sits between a CPU-side memory request port and up to two external card controllers. The controllers share one 16-bit bus, and that bus carries both the address and the data of each access. The block decodes the request address into one of two device regions. Each region has its own enable bit, and each has its own active-low chip select. The block then runs the access as a fixed sequence of bus phases. The first phase is a header word with the high card-address bits and the size, space and slot fields. The second phase carries the low card address. Two data phases follow, upper half first, then lower half.

The CPU holds its request until the block pulses `req_done`, which marks the end of the access. The device paces each data transfer with its `dev_rdy` input. While `dev_rdy` is low, the upper-half data phase repeats, so a full posted-write queue stalls the CPU. During an access the direction output is low for a write and high for a read. A request to a region that is disabled, or to an address outside both regions, completes with no bus activity and returns zero.

Top module: `cardbus_mux_master`

## Requirements
- R1: Address bits 31:28 equal to 4 select region 0 and equal to 5 select region 1. A region is used only when `cs_en[0]` (region 0) or `cs_en[1]` (region 1) is set. Any other request raises `req_done` in the first cycle after the request is taken, returns zero on `req_rdata`, and asserts no chip select.
- R2: The first phase of a transaction drives the header `{addr[25:16], size, addr[27:26], 2'b11}` with `bus_oe` high. Size is 2'b11 when `req_word` is 1 and 2'b00 when it is 0.
- R3: The second phase drives `addr[15:0]` with `bus_oe` high.
- R4: A write then drives `wdata[31:16]` and after it `wdata[15:0]`, with `bus_oe` high in both phases.
- R5: A read does not drive the bus in its data phases. It takes the upper half from `bus_in` at the clock where `dev_rdy` is high, and the lower half at the next clock. It returns `{hi,lo}` for a word and `{24'b0, lo[7:0]}` for a byte. A write returns zero.
- R6: While `dev_rdy` is low the upper-half data phase repeats. `dev_rdy` has no effect in the two address phases or in the lower-half phase. An enabled access lasts 4 plus the number of stall cycles.
- R7: While a chip select is active, `dir` is 0 for a write and 1 for a read. When no chip select is active, `dir` is 1.
- R8: `req_done` is a one-cycle pulse raised with both chip selects deasserted. The cycle after it has no chip select active either.
- R9: At most one chip select is active at a time: `cs_n[0]` for region 0 and `cs_n[1]` for region 1. It stays the same for the whole transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_en | input | 2 | Region enables, bit 0 for region 0 and bit 1 for region 1 |
| req_valid | input | 1 | CPU request, held until `req_done` |
| req_addr | input | 32 | CPU byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_word | input | 1 | 1 for a 32-bit access, 0 for a byte |
| req_wdata | input | 32 | Write data |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read result, valid with `req_done` |
| cs_n | output | 2 | Active-low chip selects, one per region |
| dir | output | 1 | Direction: 0 write, 1 read during an access |
| bus_out | output | 16 | Shared bus value driven by the block |
| bus_oe | output | 1 | Bus output enable |
| bus_in | input | 16 | Shared bus value driven by the device |
| dev_rdy | input | 1 | Device ready; low stalls the upper data phase |

## Verification
The stall case is the hardest to reach from the ports. The ready input must be low at exactly the clocks that close the upper data phase, and it must be ignored in the phases around it. The bench models the device at the falling edge. It counts the chip-select phases it has seen and lowers ready for a chosen number of upper-phase clocks. It also holds ready low through the address phases, so that any early effect of ready would show. The sweep runs every region, enable pattern, space, direction and size, with and without stalls.

// File: rtl/cardbus_mux_master.sv
module cardbus_mux_master #(
  parameter logic [3:0] REGION0 = 4'h4,
  parameter logic [3:0] REGION1 = 4'h5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cs_en,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic        req_word,
  input  logic [31:0] req_wdata,
  output logic        req_done,
  output logic [31:0] req_rdata,
  output logic [1:0]  cs_n,
  output logic        dir,
  output logic [15:0] bus_out,
  output logic        bus_oe,
  input  logic [15:0] bus_in,
  input  logic        dev_rdy
);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_ALO, S_DHI, S_DLO, S_FIN} st_t;

  st_t         st;
  logic [27:0] addr_q;
  logic        wr_q, word_q, sel_q;
  logic [31:0] wdata_q, rdata_q;
  logic [15:0] hi_q;

  wire hit0 = (req_addr[31:28] == REGION0) & cs_en[0];
  wire hit1 = (req_addr[31:28] == REGION1) & cs_en[1];
  wire active = (st == S_HDR) | (st == S_ALO) | (st == S_DHI) | (st == S_DLO);
  wire [15:0] header = {addr_q[25:16], word_q ? 2'b11 : 2'b00, addr_q[27:26], 2'b11};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      word_q  <= 1'b0;
      sel_q   <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      hi_q    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr[27:0];
          wr_q    <= req_write;
          word_q  <= req_word;
          wdata_q <= req_wdata;
          sel_q   <= hit1 & ~hit0;
          rdata_q <= '0;
          st      <= (hit0 | hit1) ? S_HDR : S_FIN;
        end
        S_HDR: st <= S_ALO;
        S_ALO: st <= S_DHI;
        S_DHI: if (dev_rdy) begin
          hi_q <= bus_in;
          st   <= S_DLO;
        end
        S_DLO: begin
          if (!wr_q) rdata_q <= word_q ? {hi_q, bus_in} : {24'b0, bus_in[7:0]};
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      S_HDR:   bus_out = header;
      S_ALO:   bus_out = addr_q[15:0];
      S_DHI:   bus_out = wr_q ? wdata_q[31:16] : 16'h0;
      S_DLO:   bus_out = wr_q ? wdata_q[15:0] : 16'h0;
      default: bus_out = 16'h0;
    endcase
  end

  assign bus_oe    = (st == S_HDR) | (st == S_ALO) | (wr_q & ((st == S_DHI) | (st == S_DLO)));
  assign cs_n      = active ? (sel_q ? 2'b01 : 2'b10) : 2'b11;
  assign dir       = ~(active & wr_q);
  assign req_done  = (st == S_FIN);
  assign req_rdata = rdata_q;

endmodule

module cardbus_mux_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  cs_n,
  input logic        dir,
  input logic [15:0] bus_out,
  input logic        bus_oe,
  input logic        req_done
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R9
  AST_SELECT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !(&$past(cs_n))) |-> $stable(cs_n)); // R9
  AST_HEADER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && (&$past(cs_n))) |-> (bus_oe && bus_out[1:0] == 2'b11 && bus_out[5:4] != 2'b01 && bus_out[5:4] != 2'b10)); // R2
  AST_UNDRIVEN_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !bus_oe) |-> dir); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> (!bus_oe && dir)); // R7
  AST_DONE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (&cs_n)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> (!req_done && (&cs_n))); // R8
endmodule

bind cardbus_mux_master cardbus_mux_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dir(dir),
  .bus_out(bus_out), .bus_oe(bus_oe), .req_done(req_done)
);

// File: tb/cardbus_mux_master_bench.sv
`timescale 1ns/1ps
module cardbus_mux_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cs_en = 2'b00;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_done;
  logic [31:0] req_rdata;
  logic [1:0]  cs_n;
  logic        dir;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic [15:0] bus_in = '0;
  logic        dev_rdy = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cardbus_mux_master u_cardbus_mux_master (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic run_txn(input logic [31:0] addr, input bit wr, input bit word,
                         input logic [31:0] wd, input logic [1:0] en, input int stall,
                         input logic [31:0] rd);
    bit hit, hi_done;
    int p, left, guard;
    logic [1:0] exp_cs;
    logic [15:0] hdr;
    logic [31:0] exp_rd;
    hit = ((addr[31:28] == 4'h4) && en[0]) || ((addr[31:28] == 4'h5) && en[1]);
    exp_cs = (addr[31:28] == 4'h4) ? 2'b10 : 2'b01;
    hdr = {addr[25:16], word ? 2'b11 : 2'b00, addr[27:26], 2'b11};
    exp_rd = (!hit || wr) ? 32'h0 : (word ? rd : {24'h0, rd[7:0]});
    p = 0; left = stall; hi_done = 0; guard = 0;
    cs_en = en; req_addr = addr; req_write = wr; req_word = word; req_wdata = wd;
    req_valid = 1'b1;
    dev_rdy = (left == 0);
    bus_in = rd[31:16];
    forever begin
      @(negedge clk);
      guard++;
      if (guard > 60) begin
        chk(1'b0, "R6 hang", guard, 60);
        break;
      end
      if (req_done) begin
        chk(p == (hit ? 4 + stall : 0), "R1/R6 phase count", p, hit ? 4 + stall : 0);
        chk(req_rdata == exp_rd, "R5/R1 rdata", req_rdata, exp_rd);
        chk(cs_n == 2'b11, "R8 cs at done", cs_n, 2'b11);
        req_valid = 1'b0;
        break;
      end
      if (cs_n != 2'b11) begin
        chk(cs_n == exp_cs, "R9 select", cs_n, exp_cs);
        chk(dir == !wr, "R7 dir", dir, !wr);
        if (p == 0) chk(bus_oe && bus_out == hdr, "R2 header", {bus_oe, bus_out}, {1'b1, hdr});
        else if (p == 1) chk(bus_oe && bus_out == addr[15:0], "R3 low addr", {bus_oe, bus_out}, {1'b1, addr[15:0]});
        else if (wr) chk(bus_oe && bus_out == (hi_done ? wd[15:0] : wd[31:16]), "R4 write data",
                         {bus_oe, bus_out}, {1'b1, hi_done ? wd[15:0] : wd[31:16]});
        else chk(!bus_oe, "R5 read undriven", bus_oe, 0);
        if (p >= 2 && !hi_done) begin
          bus_in = rd[31:16];
          dev_rdy = (left == 0);
          if (left == 0) hi_done = 1; else left--;
        end else if (p >= 2) begin
          bus_in = rd[15:0];
          dev_rdy = 1'b0;
        end else begin
          bus_in = rd[31:16];
          dev_rdy = (p == 1) ? (left == 0) : 1'b0;
        end
        p++;
      end else begin
        chk(dir && !bus_oe, "R7 idle dir", {dir, bus_oe}, 2'b10);
      end
    end
    @(negedge clk);
    chk(!req_done && cs_n == 2'b11, "R8 idle gap", {req_done, cs_n}, 3'b011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 2'b11 && !req_done && !bus_oe && dir, "R8 reset", {cs_n, req_done, bus_oe, dir}, 5'b11001);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 2'b11 && !req_done, "R1 no request idle", {cs_n, req_done}, 3'b110);
    for (int t = 0; t < 3; t++)
      for (int en = 0; en < 4; en++)
        for (int sp = 0; sp < 4; sp++)
          for (int m = 0; m < 8; m++) begin
            logic [31:0] a, wd, rd;
            int idx;
            idx = ((t * 4 + en) * 4 + sp) * 8 + m;
            a = {(t == 2) ? 4'h6 : 4'h4 + 4'(t), 2'(sp), 26'(idx * 32'h0013_5F27 + 32'h00A5_3C1)};
            wd = idx * 32'h9E37_79B1 + 32'h1234_5678;
            rd = idx * 32'h85EB_CA6B ^ 32'hC0DE_F00D;
            run_txn(a, m[0], m[1], wd, 2'(en), m[2] ? 3 : 0, rd);
          end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule